// File: doc/BRIEF.md
# Bipolar Line Decoder with Violation Detection

This block turns a received ternary line signal back into NRZ data. The line arrives already split into two unipolar rails: one carries the positive marks and the other carries the negative marks. Four line codes can be selected. Plain alternate-mark coding is the first. The other three replace long zero runs with a fixed pattern of marks: an eight-zero substitution, a six-zero substitution, and the three-zero-limit code that uses a four-symbol substitution. The decoder finds each valid substitution pattern and outputs zeros in its place.

The block raises a one-cycle error pulse in three cases: a bipolar violation that is not part of a valid pattern, a zero run longer than the selected code allows, and a symbol with marks on both rails at once. In a loopback test the decoder reads the local encoder's two rails instead of the line rails. A monitor output gives the OR of whichever rail pair is selected, so that a clock-recovery circuit outside the block can use it.

Top module: `line_decoder`

## Requirements
- R1: Both rails are sampled on the rising edge of `clk`. A mark on either rail decodes as 1 and no mark as 0. The decode latency L is set by `code_sel`: 0 selects alternate-mark with L=1, 1 selects eight-zero substitution with L=8, 2 selects six-zero substitution with L=6, and 3 selects the three-zero-limit code with L=4. A symbol sampled at edge k is shown on `nrz_out` and `err_out` after edge k+L-1.
- R2: Swapping the two rails changes neither `nrz_out` nor `err_out`.
- R3: A single-rail mark with the same polarity as the previous single-rail mark, and not part of a valid substitution, decodes as 1 with `err_out` high for that one output cycle.
- R4: With code 1, let P be the polarity of the previous mark. The pattern 0,0,0,P,-P,0,-P,P decodes as eight zeros with no error, and the polarity reference stays P. Any other arrangement of marks is decoded as ordinary marks.
- R5: With code 2, the pattern 0,P,-P,0,-P,P decodes as six zeros with no error, and the polarity reference stays P.
- R6: With code 3, either 0,0,0,P or -P,0,0,-P decodes as four zeros with no error. After the second form the polarity reference becomes -P.
- R7: The allowed run of consecutive line zeros is 15 for code 0, 8 for code 1, 6 for code 2 and 4 for code 3. `err_out` pulses during the output cycle of the first zero beyond that limit and only then.
- R8: A symbol with both rails high decodes as 1 and raises `err_out`. It does not change the polarity reference.
- R9: With `loop_en` high the decoder uses `lb_p`/`lb_n` and ignores `line_p`/`line_n`. With `loop_en` low it ignores `lb_p`/`lb_n`.
- R10: `mon_clk` is the OR of the selected rail pair, with no register on the path.
- R11: While `rst_n` is low, `nrz_out` and `err_out` are 0. Reset clears the symbol window, the zero-run count and the polarity history. After reset the first mark is never a violation, and no substitution is accepted until one single-rail mark has set the polarity reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Decoder clock; rails sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_sel | input | 2 | Line code select (0,1,2,3 as in R1) |
| line_p | input | 1 | Line rail carrying positive marks |
| line_n | input | 1 | Line rail carrying negative marks |
| loop_en | input | 1 | Selects the encoder rails instead of the line rails |
| lb_p | input | 1 | Encoder positive rail for loopback |
| lb_n | input | 1 | Encoder negative rail for loopback |
| nrz_out | output | 1 | Decoded NRZ data |
| err_out | output | 1 | One-cycle violation, double-mark or zero-run error |
| mon_clk | output | 1 | OR of the selected rails |

## Verification
The assertions check on every cycle that:
- a recognised or stripped substitution symbol never produces a 1 or an error;
- a double mark and an unmatched violation always come out as a 1 together with an error;
- a zero-run error never lasts two cycles;
- plain alternate-mark coding never recognises a substitution.

Only the bench scenarios can show the rest. These include the exact latency for each code, the full pattern shapes against each preceding polarity, and the polarity flip after the second four-symbol form. They also include the exact zero at which each code's run limit trips, the insensitivity to rail swap, the rails ignored in loopback, and the fact that reset clears history between two streams.

// File: rtl/line_dec_pkg.sv
package line_dec_pkg;

  localparam int WIN = 8;
  localparam int TW  = $clog2(WIN);

  typedef enum logic [1:0] {
    CODE_AMI  = 2'd0,
    CODE_B8ZS = 2'd1,
    CODE_B6ZS = 2'd2,
    CODE_HDB3 = 2'd3
  } code_e;

  // symbol = {negative-rail mark, positive-rail mark}
  typedef logic [WIN-1:0][1:0] win_t;

  // window position that is oldest for the selected code; equals latency-1
  function automatic logic [TW-1:0] tap_of(code_e c);
    case (c)
      CODE_B8ZS: return TW'(7);
      CODE_B6ZS: return TW'(5);
      CODE_HDB3: return TW'(3);
      default:   return TW'(0);
    endcase
  endfunction

  // longest legal run of line zeros
  function automatic int unsigned zero_limit(code_e c);
    case (c)
      CODE_B8ZS: return 8;
      CODE_B6ZS: return 6;
      CODE_HDB3: return 4;
      default:   return 15;
    endcase
  endfunction

  function automatic logic [1:0] mark_of(logic neg);
    return neg ? 2'b10 : 2'b01;
  endfunction

  // pattern check with the oldest symbol at tap_of(c); p = polarity before it
  function automatic logic sub_hit(code_e c, win_t w, logic p);
    logic [1:0] sp;
    logic [1:0] so;
    sp = mark_of(p);
    so = mark_of(!p);
    case (c)
      CODE_B8ZS: return (w[7] == 2'b00) && (w[6] == 2'b00) && (w[5] == 2'b00) &&
                        (w[4] == sp) && (w[3] == so) && (w[2] == 2'b00) &&
                        (w[1] == so) && (w[0] == sp);
      CODE_B6ZS: return (w[5] == 2'b00) && (w[4] == sp) && (w[3] == so) &&
                        (w[2] == 2'b00) && (w[1] == so) && (w[0] == sp);
      CODE_HDB3: return ((w[3] == 2'b00) && (w[2] == 2'b00) && (w[1] == 2'b00) && (w[0] == sp)) ||
                        ((w[3] == so) && (w[2] == 2'b00) && (w[1] == 2'b00) && (w[0] == so));
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ld_rail_sel.sv
module ld_rail_sel (
  input  logic       loop_en,
  input  logic       line_p,
  input  logic       line_n,
  input  logic       lb_p,
  input  logic       lb_n,
  output logic [1:0] sym,
  output logic       mon_clk
);
  always_comb begin
    sym = loop_en ? {lb_n, lb_p} : {line_n, line_p};
  end

  assign mon_clk = |sym;
endmodule

// File: rtl/ld_window.sv
module ld_window #(
  parameter int DEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            sym_in,
  input  logic                  flush,
  output logic [DEPTH-1:0][1:0] win,
  output logic [DEPTH-1:0]      kill
);
  // flush: a pattern was accepted at the tap; older slots become stripped zeros
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win  <= '0;
      kill <= '0;
    end else begin
      win[0]  <= sym_in;
      kill[0] <= 1'b0;
      for (int i = 1; i < DEPTH; i++) begin
        win[i]  <= flush ? 2'b00 : win[i-1];
        kill[i] <= flush | kill[i-1];
      end
    end
  end
endmodule

// File: rtl/ld_sub_detect.sv
module ld_sub_detect
  import line_dec_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  code_e code,
  input  win_t  win,
  input  logic  tap_kill,
  input  logic  have_mark,
  input  logic  last_neg,
  output logic  hit
);
  assign hit = have_mark & ~tap_kill & sub_hit(code, win, last_neg);

  // R1: plain alternate-mark coding has no substitution to strip
  a_r1_ami_no_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CODE_AMI) |-> !hit);
endmodule

// File: rtl/ld_out_stage.sv
module ld_out_stage
  import line_dec_pkg::*;
#(
  parameter int ZW = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  code_e      code,
  input  logic [1:0] t_sym,
  input  logic       t_kill,
  input  logic       hit,
  output logic       nrz,
  output logic       err,
  output logic       last_neg,
  output logic       have_mark
);
  logic [ZW-1:0] zrun;
  logic          t_mark, t_dbl, t_neg, live;
  logic          bpv, dbl_err, zexc;

  assign t_mark  = |t_sym;
  assign t_dbl   = &t_sym;
  assign t_neg   = t_sym[1];
  assign live    = ~t_kill & ~hit;

  assign nrz     = t_mark & live;
  assign bpv     = t_mark & ~t_dbl & live & have_mark & (t_neg == last_neg);
  assign dbl_err = t_dbl & live;
  assign zexc    = ~t_mark & live & (zrun == ZW'(zero_limit(code)));
  assign err     = bpv | dbl_err | zexc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zrun      <= '0;
      last_neg  <= 1'b0;
      have_mark <= 1'b0;
    end else if (t_kill || hit) begin
      zrun <= '0;
      if (hit && (code == CODE_HDB3) && t_mark) last_neg <= ~last_neg;
    end else if (t_mark) begin
      zrun <= '0;
      if (!t_dbl) begin
        last_neg  <= t_neg;
        have_mark <= 1'b1;
      end
    end else if (zrun != '1) begin
      zrun <= zrun + 1'b1;
    end
  end

  // R4 R5 R6: accepted and stripped symbols never produce data or error
  a_r4_sub_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (t_kill || hit) |-> (!nrz && !err));
  // R8: both rails high is a one with an error
  a_r8_dbl_one_err: assert property (@(posedge clk) disable iff (!rst_n)
    dbl_err |-> (nrz && err));
  // R3: an unmatched violation is still emitted as a one
  a_r3_bpv_kept: assert property (@(posedge clk) disable iff (!rst_n)
    bpv |-> (nrz && err));
  // R7: the zero-run error is a single-cycle pulse
  a_r7_zrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    zexc |=> !zexc);
endmodule

// File: rtl/line_decoder.sv
module line_decoder
  import line_dec_pkg::*;
#(
  parameter int ZCNT_W = 5  // must hold the largest limit plus one
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code_sel,
  input  logic       line_p,
  input  logic       line_n,
  input  logic       loop_en,
  input  logic       lb_p,
  input  logic       lb_n,
  output logic       nrz_out,
  output logic       err_out,
  output logic       mon_clk
);
  code_e         code;
  logic [1:0]    sym;
  win_t          win;
  logic [WIN-1:0] kill;
  logic [TW-1:0] tap;
  logic [1:0]    t_sym;
  logic          t_kill, hit, last_neg, have_mark;

  assign code   = code_e'(code_sel);
  assign tap    = tap_of(code);
  assign t_sym  = win[tap];
  assign t_kill = kill[tap];

  ld_rail_sel u_sel (
    .loop_en (loop_en),
    .line_p  (line_p),
    .line_n  (line_n),
    .lb_p    (lb_p),
    .lb_n    (lb_n),
    .sym     (sym),
    .mon_clk (mon_clk)
  );

  ld_window #(.DEPTH(WIN)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .sym_in (sym),
    .flush  (hit),
    .win    (win),
    .kill   (kill)
  );

  ld_sub_detect u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .code      (code),
    .win       (win),
    .tap_kill  (t_kill),
    .have_mark (have_mark),
    .last_neg  (last_neg),
    .hit       (hit)
  );

  ld_out_stage #(.ZW(ZCNT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .code      (code),
    .t_sym     (t_sym),
    .t_kill    (t_kill),
    .hit       (hit),
    .nrz       (nrz_out),
    .err       (err_out),
    .last_neg  (last_neg),
    .have_mark (have_mark)
  );
endmodule

// File: tb/line_decoder_tb.sv
module line_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] code_sel = 2'd0;
  logic       line_p = 1'b0, line_n = 1'b0, loop_en = 1'b0, lb_p = 1'b0, lb_n = 1'b0;
  logic       nrz_out, err_out, mon_clk;
  int         n_chk = 0;
  int         n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  line_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .code_sel(code_sel),
    .line_p(line_p), .line_n(line_n), .loop_en(loop_en),
    .lb_p(lb_p), .lb_n(lb_n),
    .nrz_out(nrz_out), .err_out(err_out), .mon_clk(mon_clk)
  );

  function automatic int lat_of(logic [1:0] m);
    case (m)
      2'd1:    return 8;
      2'd2:    return 6;
      2'd3:    return 4;
      default: return 1;
    endcase
  endfunction

  task automatic check(string what, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  // symbols: 0 none, + positive rail, - negative rail, D both rails
  task automatic play(string tag, logic [1:0] md, string syms, string enrz,
                      string eerr, bit swap, bit lb);
    int   n;
    int   lat;
    byte  ch;
    logic pp, nn, tmp;
    n   = syms.len();
    lat = lat_of(md);
    rst_n = 1'b0;
    line_p = 1'b0; line_n = 1'b0; lb_p = 1'b0; lb_n = 1'b0;
    repeat (2) @(negedge clk);
    check({tag, " R11 reset state"}, {nrz_out, err_out}, 2'b00);
    code_sel = md;
    loop_en  = lb;
    rst_n    = 1'b1;
    for (int c = 0; c < n + lat; c++) begin
      if (c >= lat)
        check($sformatf("%s symbol %0d", tag, c - lat), {nrz_out, err_out},
              {enrz[c-lat] == "1", eerr[c-lat] == "1"});
      ch = (c < n) ? syms[c] : "0";
      pp = (ch == "+") || (ch == "D");
      nn = (ch == "-") || (ch == "D");
      if (swap) begin tmp = pp; pp = nn; nn = tmp; end
      if (lb) begin
        lb_p = pp; lb_n = nn; line_p = 1'b1; line_n = 1'b1;
      end else begin
        line_p = pp; line_n = nn; lb_p = 1'b1; lb_n = 1'b1;
      end
      #1;
      if (c < n) check({tag, " R10 mon_clk"}, {1'b0, mon_clk}, {1'b0, pp | nn});
      @(negedge clk);
    end
  endtask

  task automatic t_ami();
    play("R1 alternate marks", 2'd0, "+0-+0-", "101101", "000000", 0, 0);
    play("R3 same-polarity mark", 2'd0, "+0+-", "1011", "0010", 0, 0);
    play("R2 swapped violation", 2'd0, "+0+-", "1011", "0010", 1, 0);
    play("R8 double mark", 2'd0, "+D-", "111", "010", 0, 0);
  endtask

  task automatic t_zero_runs();
    play("R7 15 zeros ok", 2'd0, "+000000000000000-", "10000000000000001", "00000000000000000", 0, 0);
    play("R7 16th zero", 2'd0, "+0000000000000000-", "100000000000000001", "000000000000000010", 0, 0);
    play("R7 8 zeros ok", 2'd1, "+00000000-", "1000000001", "0000000000", 0, 0);
    play("R7 9th zero", 2'd1, "+000000000-", "10000000001", "00000000010", 0, 0);
    play("R7 7th zero", 2'd2, "+0000000-", "100000001", "000000010", 0, 0);
    play("R7 4 zeros ok", 2'd3, "+0000-", "100001", "000000", 0, 0);
    play("R7 5th zero", 2'd3, "+00000-", "1000001", "0000010", 0, 0);
  endtask

  task automatic t_b8();
    play("R4 after plus", 2'd1, "+000+-0-+-", "1000000001", "0000000000", 0, 0);
    play("R4 after minus", 2'd1, "-000-+0+-+", "1000000001", "0000000000", 0, 0);
    play("R2 R4 swapped", 2'd1, "+000+-0-+-", "1000000001", "0000000000", 1, 0);
    play("R4 broken pattern", 2'd1, "+000+-0--", "100011011", "000010011", 0, 0);
  endtask

  task automatic t_b6();
    play("R5 after plus", 2'd2, "+0+-0-+-", "10000001", "00000000", 0, 0);
    play("R5 stray violation", 2'd2, "+00+0-", "100101", "000100", 0, 0);
  endtask

  task automatic t_hdb3();
    play("R6 both forms plus", 2'd3, "+000+-00-+", "1000000001", "0000000000", 0, 0);
    play("R6 both forms minus", 2'd3, "-000-+00+-", "1000000001", "0000000000", 0, 0);
    play("R6 stray violation", 2'd3, "+0+", "101", "001", 0, 0);
  endtask

  task automatic t_loop();
    play("R9 loopback plain", 2'd0, "+0-+0+", "101101", "000001", 0, 1);
    play("R9 loopback four-symbol", 2'd3, "+000+-00-+", "1000000001", "0000000000", 0, 1);
    loop_en = 1'b0;
  endtask

  task automatic t_reset_history();
    play("R11 history first", 2'd0, "+000000000000", "1000000000000", "0000000000000", 0, 0);
    play("R11 history cleared", 2'd0, "000000000000+", "0000000000001", "0000000000000", 0, 0);
  endtask

  initial begin
    @(negedge clk);
    t_ami();
    t_zero_runs();
    t_b8();
    t_b6();
    t_hdb3();
    t_loop();
    t_reset_history();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (R1..all): actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule